// File: doc/BRIEF.md
# Serial Command Port for a Voice Record Engine

This block is the serial front end of a voice record and playback engine. An SPI master (mode 0: clock idles low) selects it with an active-low select and sends a frame. The first byte is an opcode, the second a data byte, and some commands carry further bytes. The port answers on MISO while each byte arrives. It returns a status byte first, then, for read commands, a 16-bit answer.

The port does four jobs:
- It holds a 12-bit audio path configuration word and a saved copy of that word, which stands in for non-volatile storage.
- It tracks a power state.
- It passes play, record, erase and direct-address requests to the engine as one-cycle requests.
- It raises an active-low interrupt when work completes. Only a dedicated command clears it.

All serial inputs are sampled on the system clock. SCLK edges are found by comparing SCLK with its value one clock earlier, so SCLK must stay at least two system clocks high and two low.

Top module: `spi_cmd_port`

## Requirements
- R1: MOSI is taken on each rising SCLK edge, most significant bit first. MISO changes only after falling SCLK edges, and the first bit is valid two clocks after select falls. `miso_oe` is high exactly while `ss_n` is low.
- R2: The frame length in bytes depends on the opcode:
  - 0x45 and 0x65 take 3 bytes.
  - 0x05, 0x44, 0x06, 0x08 and 0x09 take 4 bytes.
  - 0x80, 0x81 and 0x82 take 6 bytes.
  - Every other opcode takes 2 bytes.
  A command acts on the clock after the last rising edge of its final byte. Any further bytes before select rises have no effect.
- R3: The first two bytes returned on MISO are the status byte. Its bits are: bit0 interrupt pending, bit1 powered, bit2 `eng_busy`, bit3 `ft_on`, bits 7:4 zero.
- R4: Read commands return a 16-bit word, low byte in the third byte and high byte in the fourth. The words are:
  - 0x05: {8'h00, status}
  - 0x44: the configuration word
  - 0x06: `play_ptr`
  - 0x08: `rec_ptr`
  - 0x09: {8'h00, DEV_ID}
- R5: After reset, the configuration word and its saved copy are 0x440. The port is powered down, no interrupt is pending, `eng_req` is low and `miso_oe` is low.
- R6: Opcodes 0x45 and 0x65 set the configuration word to {third byte [3:0], second byte}.
- R7: Opcode 0x46 copies the configuration word into the saved copy. Opcode 0x47 copies the saved copy back.
- R8: Power state and engine requests:
  - 0x01 powers the port up and 0x07 powers it down.
  - Opcodes 0x02, 0x03, 0x40, 0x41, 0x42, 0x43, 0x48, 0x49, 0x80, 0x81 and 0x82 pulse `eng_req` for one clock, carrying the opcode, only while powered.
  - For 0x80–0x82, `eng_start` = {byte3, byte2} and `eng_end` = {byte5, byte4}, truncated to 11 bits. For every other forwarded opcode both are zero.
- R9: The interrupt becomes pending one clock after an `eng_done` pulse, or when 0x01, 0x07, 0x45, 0x65, 0x46 or 0x47 completes. Only opcode 0x04 clears it, and a set in the same clock wins. `int_n` is the inverse of pending.
- R10: `ft_on` equals the inverse of configuration bit 6 while powered, and the inverse of `ft_pin_n` while powered down.
- R11: Raising select mid-frame discards the partial frame, and the next frame starts from bit zero. Opcodes outside the lists above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the MISO pad |
| int_n | output | 1 | Active-low interrupt |
| eng_req | output | 1 | One-cycle request to the engine |
| eng_op | output | 8 | Opcode of the request |
| eng_start | output | 11 | Start row for direct-access requests |
| eng_end | output | 11 | End row for direct-access requests |
| eng_busy | input | 1 | Engine busy flag, reported in status |
| eng_done | input | 1 | Engine completion pulse |
| play_ptr | input | 11 | Engine play row pointer |
| rec_ptr | input | 11 | Engine record row pointer |
| cfg | output | 12 | Audio path configuration word |
| ft_pin_n | input | 1 | External feed-through request, active low |
| ft_on | output | 1 | Feed-through path enable |

## Verification
A bit or byte counter that slips shows up on MISO within the same frame: the returned bytes come back shifted. It also shows up as a configuration load or engine request that fires a byte early, late or twice. A wrong power or interrupt flag shows on `int_n`, `ft_on` or the next status byte within a clock or one frame. The bench's model follows every frame and compares `cfg`, `int_n`, `ft_on`, `miso_oe` and the request outputs on every clock.

// File: rtl/spi_cmd_port.sv
module spi_cmd_port #(
  parameter int ADDR_W = 11,
  parameter int CFG_W = 12,
  parameter logic [CFG_W-1:0] CFG_RST = 12'h440,
  parameter logic [7:0] DEV_ID = 8'h5D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic              int_n,
  output logic              eng_req,
  output logic [7:0]        eng_op,
  output logic [ADDR_W-1:0] eng_start,
  output logic [ADDR_W-1:0] eng_end,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [ADDR_W-1:0] play_ptr,
  input  logic [ADDR_W-1:0] rec_ptr,
  output logic [CFG_W-1:0]  cfg,
  input  logic              ft_pin_n,
  output logic              ft_on
);

  logic       sclk_q, ss_q;
  logic [2:0] bit_cnt, byte_cnt;
  logic [6:0] rx;
  logic [7:0] op, b1, b2, b3, b4, tx;
  logic [CFG_W-1:0] nv;
  logic       powered, int_pend;

  function automatic logic [3:0] frame_len(input logic [7:0] o);
    case (o)
      8'h45, 8'h65:                      return 4'd3;
      8'h05, 8'h44, 8'h06, 8'h08, 8'h09: return 4'd4;
      8'h80, 8'h81, 8'h82:               return 4'd6;
      default:                           return 4'd2;
    endcase
  endfunction

  function automatic logic to_engine(input logic [7:0] o);
    case (o)
      8'h02, 8'h03, 8'h40, 8'h41, 8'h42, 8'h43,
      8'h48, 8'h49, 8'h80, 8'h81, 8'h82: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  wire rise  = ~ss_n & sclk & ~sclk_q;
  wire fall  = ~ss_n & ~sclk & sclk_q;
  wire start = ~ss_n & ss_q;
  wire [7:0] lb = {rx, mosi};
  wire byte_end = rise && (bit_cnt == 3'd7);
  wire exec = byte_end && (({1'b0, byte_cnt} + 4'd1) == frame_len(op));
  wire direct = (op == 8'h80) || (op == 8'h81) || (op == 8'h82);

  wire [7:0] status = {4'b0000, ft_on, eng_busy, powered, int_pend};

  logic [15:0] resp;
  always_comb begin
    case (op)
      8'h05:   resp = {8'h00, status};
      8'h44:   resp = 16'(cfg);
      8'h06:   resp = 16'(play_ptr);
      8'h08:   resp = 16'(rec_ptr);
      8'h09:   resp = {8'h00, DEV_ID};
      default: resp = 16'h0000;
    endcase
  end

  logic [7:0] next_tx;
  always_comb begin
    case (byte_cnt)
      3'd1:    next_tx = status;
      3'd2:    next_tx = resp[7:0];
      3'd3:    next_tx = resp[15:8];
      default: next_tx = 8'h00;
    endcase
  end

  wire set_int = eng_done ||
                 (exec && (op == 8'h01 || op == 8'h07 || op == 8'h45 ||
                           op == 8'h65 || op == 8'h46 || op == 8'h47));
  wire clr_int = exec && (op == 8'h04);

  assign miso    = tx[7];
  assign miso_oe = ~ss_n;
  assign int_n   = ~int_pend;
  assign ft_on   = powered ? ~cfg[6] : ~ft_pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      ss_q      <= 1'b1;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      rx        <= '0;
      op        <= '0;
      b1        <= '0;
      b2        <= '0;
      b3        <= '0;
      b4        <= '0;
      tx        <= '0;
      cfg       <= CFG_RST;
      nv        <= CFG_RST;
      powered   <= 1'b0;
      int_pend  <= 1'b0;
      eng_req   <= 1'b0;
      eng_op    <= '0;
      eng_start <= '0;
      eng_end   <= '0;
    end else begin
      sclk_q  <= sclk;
      ss_q    <= ss_n;
      eng_req <= 1'b0;
      int_pend <= (int_pend & ~clr_int) | set_int;

      if (ss_n) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (start) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        tx       <= status;
      end else begin
        if (rise) begin
          rx      <= lb[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
            case (byte_cnt)
              3'd0: op <= lb;
              3'd1: b1 <= lb;
              3'd2: b2 <= lb;
              3'd3: b3 <= lb;
              3'd4: b4 <= lb;
              default: ;
            endcase
          end
        end
        if (fall) begin
          if (bit_cnt == 3'd0 && byte_cnt != 3'd0) tx <= next_tx;
          else if (bit_cnt != 3'd0)                tx <= {tx[6:0], 1'b0};
        end
      end

      if (exec) begin
        case (op)
          8'h01:        powered <= 1'b1;
          8'h07:        powered <= 1'b0;
          8'h45, 8'h65: cfg <= CFG_W'({lb, b1});
          8'h46:        nv <= cfg;
          8'h47:        cfg <= nv;
          default: ;
        endcase
        if (to_engine(op) && powered) begin
          eng_req   <= 1'b1;
          eng_op    <= op;
          eng_start <= direct ? ADDR_W'({b3, b2}) : '0;
          eng_end   <= direct ? ADDR_W'({lb, b4}) : '0;
        end
      end
    end
  end

endmodule

// File: rtl/spi_cmd_port_chk.sv
module spi_cmd_port_chk #(
  parameter int CFG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ss_n,
  input logic             miso_oe,
  input logic             int_n,
  input logic             eng_req,
  input logic [7:0]       eng_op,
  input logic             eng_done,
  input logic             powered,
  input logic [CFG_W-1:0] cfg
);

  // R1
  miso_oe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe == !ss_n);

  // R8
  eng_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> powered);

  // R8
  eng_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);

  // R8
  eng_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> (eng_op == 8'h02 || eng_op == 8'h03 || eng_op == 8'h40 ||
                 eng_op == 8'h41 || eng_op == 8'h42 || eng_op == 8'h43 ||
                 eng_op == 8'h48 || eng_op == 8'h49 || eng_op == 8'h80 ||
                 eng_op == 8'h81 || eng_op == 8'h82));

  // R9
  int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !int_n);

  // R9
  int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> $past(!ss_n));

  // R6
  cfg_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(!ss_n));

endmodule

bind spi_cmd_port spi_cmd_port_chk #(.CFG_W(CFG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .miso_oe(miso_oe), .int_n(int_n),
  .eng_req(eng_req), .eng_op(eng_op), .eng_done(eng_done),
  .powered(powered), .cfg(cfg)
);

// File: tb/spi_cmd_port_tb.sv
module spi_cmd_port_tb_top;
  localparam int CLK_NS = 10;
  localparam logic [7:0] DEVID = 8'h5D;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic eng_busy = 1'b0, eng_done = 1'b0, ft_pin_n = 1'b1;
  logic [10:0] play_ptr = '0, rec_ptr = '0;
  logic miso, miso_oe, int_n, eng_req, ft_on;
  logic [7:0] eng_op;
  logic [10:0] eng_start, eng_end;
  logic [11:0] cfg;

  spi_cmd_port #(.DEV_ID(DEVID)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .int_n(int_n), .eng_req(eng_req),
    .eng_op(eng_op), .eng_start(eng_start), .eng_end(eng_end),
    .eng_busy(eng_busy), .eng_done(eng_done), .play_ptr(play_ptr),
    .rec_ptr(rec_ptr), .cfg(cfg), .ft_pin_n(ft_pin_n), .ft_on(ft_on)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [11:0] exp_cfg = 12'h440, exp_nv = 12'h440;
  logic exp_int = 1'b0, exp_pow = 1'b0, exp_req = 1'b0, mon_on = 1'b0;
  logic [7:0] exp_op = '0;
  logic [10:0] exp_st = '0, exp_en = '0;
  logic [7:0] txq[$], rxq[$];
  logic [7:0] st;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic ft_exp();
    return exp_pow ? ~exp_cfg[6] : ~ft_pin_n;
  endfunction

  function automatic logic [7:0] status_exp();
    return {4'b0000, ft_exp(), eng_busy, exp_pow, exp_int};
  endfunction

  function automatic int flen(input logic [7:0] o);
    if (o == 8'h45 || o == 8'h65) return 3;
    if (o == 8'h05 || o == 8'h44 || o == 8'h06 || o == 8'h08 || o == 8'h09) return 4;
    if (o == 8'h80 || o == 8'h81 || o == 8'h82) return 6;
    return 2;
  endfunction

  task automatic model_exec();
    logic [7:0] o;
    o = txq[0];
    case (o)
      8'h01: begin exp_pow = 1'b1; exp_int = 1'b1; end
      8'h07: begin exp_pow = 1'b0; exp_int = 1'b1; end
      8'h04: exp_int = 1'b0;
      8'h45, 8'h65: begin exp_cfg = {txq[2][3:0], txq[1]}; exp_int = 1'b1; end
      8'h46: begin exp_nv = exp_cfg; exp_int = 1'b1; end
      8'h47: begin exp_cfg = exp_nv; exp_int = 1'b1; end
      8'h02, 8'h03, 8'h40, 8'h41, 8'h42, 8'h43, 8'h48, 8'h49: if (exp_pow) begin
        exp_req = 1'b1; exp_op = o; exp_st = '0; exp_en = '0;
      end
      8'h80, 8'h81, 8'h82: if (exp_pow) begin
        exp_req = 1'b1; exp_op = o;
        exp_st = {txq[3][2:0], txq[2]};
        exp_en = {txq[5][2:0], txq[4]};
      end
      default: ;
    endcase
  endtask

  // nbits = 0 sends every queued byte
  task automatic send(input int nbits);
    int n, len;
    logic [7:0] cur;
    n = (nbits == 0) ? txq.size() * 8 : nbits;
    len = flen(txq[0]);
    rxq = {};
    cur = '0;
    @(negedge clk); ss_n = 1'b0; sclk = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = txq[i/8][7 - (i%8)];
      repeat (2) @(negedge clk);
      cur = {cur[6:0], miso};
      sclk = 1'b1;
      @(posedge clk); #1;
      if (i % 8 == 7) begin
        rxq.push_back(cur);
        if (i / 8 == len - 1) model_exec();
      end
      @(posedge clk); #1 exp_req = 1'b0;
      @(negedge clk); sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    ss_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic engine_done();
    @(negedge clk); eng_done = 1'b1;
    @(posedge clk); #1 exp_int = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      chk("R6 cfg", {20'b0, cfg}, {20'b0, exp_cfg});
      chk("R9 int_n", {31'b0, int_n}, {31'b0, ~exp_int});
      chk("R10 ft_on", {31'b0, ft_on}, {31'b0, ft_exp()});
      chk("R8 eng_req", {31'b0, eng_req}, {31'b0, exp_req});
      chk("R1 miso_oe", {31'b0, miso_oe}, {31'b0, ~ss_n});
      if (exp_req) begin
        chk("R8 eng_op", {24'b0, eng_op}, {24'b0, exp_op});
        chk("R8 eng_start", {21'b0, eng_start}, {21'b0, exp_st});
        chk("R8 eng_end", {21'b0, eng_end}, {21'b0, exp_en});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R2 watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state
    chk("R5 cfg reset", {20'b0, cfg}, 32'h440);
    chk("R5 int_n reset", {31'b0, int_n}, 32'h1);
    chk("R5 eng_req reset", {31'b0, eng_req}, 32'h0);
    chk("R5 miso_oe reset", {31'b0, miso_oe}, 32'h0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 status read, powered down
    st = status_exp();
    txq = '{8'h05, 8'h00, 8'h00, 8'h00}; send(0);
    chk("R3 status byte0", {24'b0, rxq[0]}, {24'b0, st});
    chk("R3 status byte1", {24'b0, rxq[1]}, {24'b0, st});
    chk("R4 status low", {24'b0, rxq[2]}, {24'b0, st});
    chk("R4 status high", {24'b0, rxq[3]}, 32'h0);

    // R4 R5 config read shows reset default
    txq = '{8'h44, 8'h00, 8'h00, 8'h00}; send(0);
    chk("R5 cfg low", {24'b0, rxq[2]}, 32'h40);
    chk("R5 cfg high", {24'b0, rxq[3]}, 32'h04);

    // R8 engine op while powered down is dropped
    txq = '{8'h40, 8'h00}; send(0);
    chk("R8 no int when down", {31'b0, int_n}, 32'h1);

    // R8 R9 power up
    txq = '{8'h01, 8'h00}; send(0);
    chk("R9 int after power up", {31'b0, int_n}, 32'h0);
    txq = '{8'h04, 8'h00}; send(0);
    chk("R9 int cleared", {31'b0, int_n}, 32'h1);

    // R6 R10 load config
    txq = '{8'h45, 8'hBC, 8'h0A}; send(0);
    chk("R6 cfg load", {20'b0, cfg}, 32'hABC);
    chk("R10 ft from cfg bit6", {31'b0, ft_on}, 32'h1);
    txq = '{8'h44, 8'h00, 8'h00, 8'h00}; send(0);
    chk("R4 cfg low", {24'b0, rxq[2]}, 32'hBC);
    chk("R4 cfg high", {24'b0, rxq[3]}, 32'h0A);

    // R7 save, overwrite, reload
    txq = '{8'h46, 8'h00}; send(0);
    txq = '{8'h65, 8'h23, 8'h51}; send(0);
    chk("R6 alt load", {20'b0, cfg}, 32'h123);
    txq = '{8'h47, 8'h00}; send(0);
    chk("R7 reload", {20'b0, cfg}, 32'hABC);
    txq = '{8'h04, 8'h00}; send(0);

    // R8 R9 forwarded play and completion
    txq = '{8'h40, 8'h00}; send(0);
    chk("R9 no int before done", {31'b0, int_n}, 32'h1);
    engine_done();
    chk("R9 int after done", {31'b0, int_n}, 32'h0);
    txq = '{8'h04, 8'h00}; send(0);

    // R8 direct access with addresses
    txq = '{8'h80, 8'h00, 8'hA5, 8'h03, 8'hFF, 8'h07}; send(0);

    // R3 R4 pointers, device id, busy bit
    eng_busy = 1'b1; play_ptr = 11'h5C3; rec_ptr = 11'h123;
    st = status_exp();
    txq = '{8'h06, 8'h00, 8'h00, 8'h00}; send(0);
    chk("R3 busy status", {24'b0, rxq[0]}, {24'b0, st});
    chk("R4 play low", {24'b0, rxq[2]}, 32'hC3);
    chk("R4 play high", {24'b0, rxq[3]}, 32'h05);
    txq = '{8'h08, 8'h00, 8'h00, 8'h00}; send(0);
    chk("R4 rec low", {24'b0, rxq[2]}, 32'h23);
    chk("R4 rec high", {24'b0, rxq[3]}, 32'h01);
    txq = '{8'h09, 8'h00, 8'h00, 8'h00}; send(0);
    chk("R4 devid low", {24'b0, rxq[2]}, {24'b0, DEVID});
    chk("R4 devid high", {24'b0, rxq[3]}, 32'h0);
    eng_busy = 1'b0;

    // R11 abort mid-byte
    txq = '{8'h45, 8'h77, 8'h03}; send(20);
    chk("R11 abort keeps cfg", {20'b0, cfg}, 32'hABC);
    txq = '{8'h44, 8'h00, 8'h00, 8'h00}; send(0);
    chk("R11 realigned read", {24'b0, rxq[2]}, 32'hBC);

    // R11 unknown opcode
    txq = '{8'h5A, 8'h00}; send(0);
    chk("R11 unknown no int", {31'b0, int_n}, 32'h1);

    // R2 trailing bytes ignored
    txq = '{8'h45, 8'h11, 8'h02, 8'hFF}; send(0);
    chk("R2 cfg with trailer", {20'b0, cfg}, 32'h211);
    txq = '{8'h01, 8'h00, 8'h07, 8'h00}; send(0);
    st = status_exp();
    txq = '{8'h05, 8'h00, 8'h00, 8'h00}; send(0);
    chk("R2 still powered", {24'b0, rxq[0]}, {24'b0, st});
    chk("R2 powered bit", {31'b0, rxq[0][1]}, 32'h1);

    // R10 power down hands feed-through to the pin
    txq = '{8'h07, 8'h00}; send(0);
    @(negedge clk); ft_pin_n = 1'b0;
    @(negedge clk);
    chk("R10 pin low", {31'b0, ft_on}, 32'h1);
    ft_pin_n = 1'b1;
    @(negedge clk);
    chk("R10 pin high", {31'b0, ft_on}, 32'h0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule